// File: doc/BRIEF.md
# Latched GPIO Interrupt Capture

This block is the input side of a GPIO expander: it watches a bank of pins, freezes the level of a pin at its first change when that pin is set to latch, records which pins changed in an interrupt status register, and pulls an active-low interrupt line. Each pin first crosses into the clock domain through a synchronizer. A change is any difference between the synchronized level and the level that the host was last given by an input-port read.

The host reads through a read-strobe bus with one registered result. One address returns the input port and another returns the status bits. The two reads are separate transactions, so a pin can change between them. The block keeps that change latched and keeps its status bit set until the next input-port read. Reading the status register leaves every bit in place. Reading the input port gives the captured levels, takes them as the new reference, releases every latch and clears the status bits. A pulse that ends before the read therefore still shows in the status register and in the captured level, and its return edge becomes a fresh change after the read.

Top module: `gpio_irq_capture`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rd_data_o` is 0 and `irq_n_o` is 1.
- R2: A pin change passes through two synchronizer flops and one status flop. When a pin is driven between rising edges k and k+1, `irq_n_o` first goes low after rising edge k+3 and is still high after edge k+2.
- R3: On a line with `lat_en_i` set, the input-port read (address 0) returns the level captured at the line's first change, even if the pin has returned to its earlier level before the read.
- R4: A change on an unmasked latched line sets its status bit. The bit stays set until an input-port read, and `irq_n_o` is low while any status bit is set on a line whose `mask_i` bit is 0.
- R5: A status read (address 1) returns the status bits with bit i for line i. It clears neither the status bits nor the interrupt.
- R6: On the rising edge that samples `rd_stb_i` with address 0, all status bits and latches clear, and `irq_n_o` is high in the following cycle.
- R7: A line whose `mask_i` bit is 1 never sets its status bit and never pulls `irq_n_o` low.
- R8: On a line with `lat_en_i` clear, the input port shows the live synchronized level. Its status bit follows whether that level differs from the last value read, so a return before the read clears it.
- R9: A change on another line after a status read and before the input-port read is latched, sets its status bit and appears in that input-port read.
- R10: `rd_data_o` is registered. It updates only on an edge that samples `rd_stb_i`, holds between strobes, and returns 0 for any address other than 0 or 1.
- R11: The value returned by an input-port read becomes the new reference. A latched line whose pin already differs from that value latches again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | N_LINES | Asynchronous pin levels |
| mask_i | input | N_LINES | Per-line interrupt mask, 1 = masked |
| lat_en_i | input | N_LINES | Per-line latch enable, 1 = latch at first change |
| rd_stb_i | input | 1 | Read strobe, one cycle per read |
| rd_addr_i | input | 2 | Read address: 0 input port, 1 status |
| rd_data_o | output | N_LINES | Registered read result |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with its defaults: eight lines and two synchronizer stages. With eight lines, one run can drive latched, unlatched and masked lines side by side. A pulse on one line can land between a status read and an input-port read of another. The two-stage setting fixes the three-cycle path from pin to interrupt that the directed latency checks count on.

// File: rtl/gic_pkg.sv
package gic_pkg;

    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_INPUT  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd1;

    // Per-line capture state.
    typedef struct packed {
        logic ref_lvl;   // level last handed to the host
        logic hold;      // level frozen at first change
        logic latched;   // capture is holding
        logic status;    // pending interrupt bit
    } line_state_t;

endpackage

// File: rtl/gic_sync.sv
module gic_sync #(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned STAGES  = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_LINES-1:0] async_i,
    output logic [N_LINES-1:0] sync_o
);

    logic [N_LINES-1:0] stage_d [STAGES];
    logic [N_LINES-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gic_line.sv
module gic_line
    import gic_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,     // synchronized pin level
    input  logic mask_i,
    input  logic lat_en_i,
    input  logic take_i,      // input-port read this cycle
    output logic port_o,      // value the input port shows
    output logic status_o,
    output logic latched_o,
    output logic hold_o
);

    line_state_t st_d, st_q;
    logic        differs;

    always_comb begin
        st_d    = st_q;
        port_o  = st_q.latched ? st_q.hold : level_i;
        differs = (level_i != st_q.ref_lvl);

        if (take_i) begin
            // The host now owns this value: it becomes the reference.
            st_d.ref_lvl = port_o;
            st_d.latched = 1'b0;
            st_d.status  = 1'b0;
        end else if (lat_en_i) begin
            if (!st_q.latched) begin
                st_d.latched = differs;
                st_d.hold    = level_i;
                st_d.status  = differs & ~mask_i;
            end
        end else begin
            // Unlatched: status tracks a live pending difference.
            st_d.latched = 1'b0;
            st_d.status  = differs & ~mask_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o  = st_q.status;
    assign latched_o = st_q.latched;
    assign hold_o    = st_q.hold;

endmodule

// File: rtl/gic_regread.sv
module gic_regread
    import gic_pkg::*;
#(
    parameter int unsigned N_LINES = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               stb_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [N_LINES-1:0] port_i,
    input  logic [N_LINES-1:0] status_i,
    output logic [N_LINES-1:0] data_o
);

    logic [N_LINES-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (stb_i) begin
            unique case (addr_i)
                ADDR_INPUT:  data_d = port_i;
                ADDR_STATUS: data_d = status_i;
                default:     data_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign data_o = data_q;

endmodule

// File: rtl/gpio_irq_capture.sv
module gpio_irq_capture
    import gic_pkg::*;
#(
    parameter int unsigned N_LINES     = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_LINES-1:0] pin_i,
    input  logic [N_LINES-1:0] mask_i,
    input  logic [N_LINES-1:0] lat_en_i,
    input  logic               rd_stb_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [N_LINES-1:0] rd_data_o,
    output logic               irq_n_o
);

    logic [N_LINES-1:0] level_s;
    logic [N_LINES-1:0] port_vec;
    logic [N_LINES-1:0] status_vec;
    logic [N_LINES-1:0] latched_vec;
    logic [N_LINES-1:0] hold_vec;
    logic               take;

    assign take = rd_stb_i && (rd_addr_i == ADDR_INPUT);

    gic_sync #(
        .N_LINES (N_LINES),
        .STAGES  (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pin_i),
        .sync_o  (level_s)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        gic_line u_line (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .level_i   (level_s[i]),
            .mask_i    (mask_i[i]),
            .lat_en_i  (lat_en_i[i]),
            .take_i    (take),
            .port_o    (port_vec[i]),
            .status_o  (status_vec[i]),
            .latched_o (latched_vec[i]),
            .hold_o    (hold_vec[i])
        );
    end

    gic_regread #(
        .N_LINES (N_LINES)
    ) u_read (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .stb_i    (rd_stb_i),
        .addr_i   (rd_addr_i),
        .port_i   (port_vec),
        .status_i (status_vec),
        .data_o   (rd_data_o)
    );

    assign irq_n_o = ~|(status_vec & ~mask_i);

endmodule

// File: rtl/gic_checker.sv
module gic_checker
    import gic_pkg::*;
#(
    parameter int unsigned N_LINES = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [N_LINES-1:0] mask_i,
    input logic [N_LINES-1:0] lat_en_i,
    input logic               rd_stb_i,
    input logic [ADDR_W-1:0]  rd_addr_i,
    input logic [N_LINES-1:0] rd_data_o,
    input logic               irq_n_o,
    input logic [N_LINES-1:0] status_vec,
    input logic [N_LINES-1:0] latched_vec,
    input logic [N_LINES-1:0] hold_vec
);

    logic take_c, peek_c;
    assign take_c = rd_stb_i && (rd_addr_i == ADDR_INPUT);
    assign peek_c = rd_stb_i && (rd_addr_i == ADDR_STATUS);

    AST_TAKE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_c |=> (status_vec == '0) && (latched_vec == '0)); // R6

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_n_o |-> (status_vec != '0)); // R4

    AST_MASKED_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_vec & ~$past(status_vec) & $past(mask_i)) == '0)); // R7

    AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !take_c |=> (!$stable(lat_en_i) ||
                     (($past(status_vec & lat_en_i) & ~status_vec) == '0))); // R4

    AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !take_c |=> (($past(latched_vec) & (hold_vec ^ $past(hold_vec))) == '0)); // R3

    AST_PEEK_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        peek_c |=> (rd_data_o == $past(status_vec))); // R5

    AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_stb_i |=> $stable(rd_data_o)); // R10

endmodule

bind gpio_irq_capture gic_checker #(
    .N_LINES (N_LINES)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mask_i      (mask_i),
    .lat_en_i    (lat_en_i),
    .rd_stb_i    (rd_stb_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .irq_n_o     (irq_n_o),
    .status_vec  (status_vec),
    .latched_vec (latched_vec),
    .hold_vec    (hold_vec)
);

// File: tb/gpio_irq_capture_tb.sv
`timescale 1ns/1ps
module gpio_irq_capture_tb;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin = '0;
    logic [N-1:0] mask = '0;
    logic [N-1:0] lat_en = '0;
    logic         rd_stb = 1'b0;
    logic [1:0]   rd_addr = '0;
    logic [N-1:0] rd_data;
    logic         irq_n;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_capture #(.N_LINES(N), .SYNC_STAGES(2)) u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .pin_i     (pin),
        .mask_i    (mask),
        .lat_en_i  (lat_en),
        .rd_stb_i  (rd_stb),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .irq_n_o   (irq_n)
    );

    // Expected-value state, built from the requirements.
    logic [N-1:0] m_s1, m_s2, m_ref, m_hold, m_lat, m_st, m_rd;

    function automatic logic [N-1:0] exp_port();
        return (m_lat & m_hold) | (~m_lat & m_s2);
    endfunction

    function automatic logic exp_irq_n();
        return ~|(m_st & ~mask);
    endfunction

    task automatic model_reset();
        m_s1 = '0; m_s2 = '0; m_ref = '0; m_hold = '0;
        m_lat = '0; m_st = '0; m_rd = '0;
    endtask

    task automatic model_step();
        logic [N-1:0] port, nref, nhold, nlat, nst;
        port = exp_port();
        nref = m_ref; nhold = m_hold; nlat = m_lat; nst = m_st;
        if (rd_stb) m_rd = (rd_addr == 2'd0) ? port : (rd_addr == 2'd1) ? m_st : '0;
        for (int i = 0; i < N; i++) begin
            logic diff;
            diff = m_s2[i] ^ m_ref[i];
            if (rd_stb && rd_addr == 2'd0) begin
                nref[i] = port[i]; nlat[i] = 1'b0; nst[i] = 1'b0;
            end else if (lat_en[i]) begin
                if (!m_lat[i]) begin
                    nlat[i] = diff; nhold[i] = m_s2[i]; nst[i] = diff & ~mask[i];
                end
            end else begin
                nlat[i] = 1'b0; nst[i] = diff & ~mask[i];
            end
        end
        m_ref = nref; m_hold = nhold; m_lat = nlat; m_st = nst;
        m_s2 = m_s1; m_s1 = pin;
    endtask

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: model follows the edge, outputs compared at the next falling edge.
    task automatic tick();
        @(posedge clk);
        if (rst_n) model_step(); else model_reset();
        @(negedge clk);
        check("R4 irq", {{(N-1){1'b0}}, irq_n}, {{(N-1){1'b0}}, exp_irq_n()});
        check("R10 rd_data", rd_data, m_rd);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic do_read(input logic [1:0] a);
        rd_addr = a; rd_stb = 1'b1;
        tick();
        rd_stb = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd2024);
        model_reset();
        @(negedge clk);
        check("R1 rd_data in reset", rd_data, '0);
        check("R1 irq in reset", {{(N-1){1'b0}}, irq_n}, 8'h01);
        ticks(2);
        rst_n = 1'b1;
        tick();
        check("R1 rd_data after reset", rd_data, '0);
        check("R1 irq after reset", {{(N-1){1'b0}}, irq_n}, 8'h01);

        // R2 latency and R3/R4 short pulse on a latched line
        lat_en = 8'hFF; mask = 8'h00;
        pin[0] = 1'b1;
        tick(); check("R2 edge k+1", {7'b0, irq_n}, 8'h01);
        pin[0] = 1'b0;
        tick(); check("R2 edge k+2", {7'b0, irq_n}, 8'h01);
        tick(); check("R2 edge k+3", {7'b0, irq_n}, 8'h00);
        ticks(3);
        check("R4 held after pulse", {7'b0, irq_n}, 8'h00);
        do_read(2'd1);
        check("R5 status read", rd_data, 8'h01);
        check("R5 irq kept", {7'b0, irq_n}, 8'h00);
        // R9: another line changes between the two reads
        pin[1] = 1'b1;
        ticks(4);
        do_read(2'd0);
        check("R3 R9 captured levels", rd_data, 8'h03);
        check("R6 irq released", {7'b0, irq_n}, 8'h01);
        // R11: pin0 already back at 0, differs from new reference 1
        tick();
        check("R11 re-latch", {7'b0, irq_n}, 8'h00);
        do_read(2'd1);
        check("R11 status bit0", rd_data, 8'h01);
        do_read(2'd0);
        check("R11 second read", rd_data, 8'h02);
        ticks(2);

        // R7 masked line
        mask = 8'h80;
        pin[7] = 1'b1;
        ticks(5);
        check("R7 masked irq", {7'b0, irq_n}, 8'h01);
        do_read(2'd1);
        check("R7 masked status", rd_data, 8'h00);
        do_read(2'd0);
        ticks(2);
        mask = 8'h00;

        // R8 unlatched return clears
        lat_en = 8'h00;
        pin[2] = 1'b1;
        ticks(4);
        do_read(2'd1);
        check("R8 unlatched pending", rd_data, 8'h04);
        pin[2] = 1'b0;
        ticks(4);
        check("R8 returned irq", {7'b0, irq_n}, 8'h01);
        do_read(2'd0);
        check("R8 live level", rd_data, 8'h82);

        // R10 unused address
        do_read(2'd3);
        check("R10 other address", rd_data, 8'h00);
        ticks(3);
        check("R10 held", rd_data, 8'h00);

        // Random traffic
        for (int ph = 0; ph < 8; ph++) begin
            lat_en = N'($urandom);
            mask   = N'($urandom);
            for (int c = 0; c < 400; c++) begin
                if ($urandom_range(0, 3) == 0) pin = pin ^ (N'(1) << $urandom_range(0, N-1));
                rd_stb  = ($urandom_range(0, 5) == 0);
                rd_addr = 2'($urandom_range(0, 2));
                tick();
            end
            rd_stb = 1'b0;
            do_read(2'd0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule